// File: doc/BRIEF.md
# Length-Addressed Three-Wire Configuration Slave

This block receives configuration commands for a tuning synthesizer over a three-wire serial bus made of an enable line, a bit clock and a data line. While enable is high, each rising edge of the bus clock shifts in one data bit, least significant bit first. The block also counts these edges. When enable falls, the edge count (16 or 24) and the two most significant bits of the received word together select one register. The whole payload is then committed to that register in a single system clock cycle.

The bus lines are asynchronous to the system clock. Each line is resynchronized and its edges are detected in the system clock domain. The system clock must therefore run at least eight times faster than the bus clock. A command that matches no register is dropped, so other devices can share the same three wires. The outputs are the decoded fields:

- reference and feedback divider values;
- charge-pump current code;
- alignment DAC gain and offset codes;
- a three-bit level code;
- switch controls;
- an oscillator-buffer disable;
- a crystal tuning-capacitance code.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset, both dividers read 2, the four switch controls read 1 (released), the buffer disable reads 0, both DAC gains read 128, both DAC offsets read 32, and every other field reads 0.
- R2: A data bit is taken on each bus clock rising edge while enable is high. The first bit taken becomes bit 0 of the command word, and later bits fill successively higher positions.
- R3: A 24-bit command with word bits 23:22 = 00 loads these fields:
  - bits 15:0: the reference divider;
  - bits 18:16: the level code;
  - bit 19: the buffer disable (0 = buffer running);
  - bits 21:20: the pump current code (00/01/10/11 select 25/100/500/2000 µA).
- R4: A 24-bit command with word bits 23:22 = 01 loads these fields:
  - bits 15:0: the feedback divider;
  - bits 19:16: switch controls 0 to 3 (1 = released, 0 = pulled low);
  - bit 20: the DAC mode (1 = AM, 0 = FM);
  - bit 21: the status flag.
- R5: A 16-bit command with word bits 15:14 = 00 loads DAC1, and one with bits 15:14 = 01 loads DAC2. In both, bits 7:0 are the gain and bits 13:8 are the offset.
- R6: A 16-bit command with word bits 15:14 = 10 loads the crystal tuning code from bits 13:6. The code's top bit is the fixed 8 pF step. Bits 5:0 have no effect on any output.
- R7: A command with any edge count other than 16 or 24 leaves every output unchanged. This includes counts above 24: such edges are still counted, but only the last 24 bits are kept.
- R8: A 16-bit command with address 11, and a 24-bit command with address 10 or 11, leave every output unchanged.
- R9: A 24-bit divider command whose 16-bit divider value is 0 or 1 is dropped entirely and leaves every output unchanged. Both dividers therefore always stay in the range 2 to 65535.
- R10: Outputs never change while a command is in progress. All fields of an accepted command change together, in the single system clock cycle after the falling edge of the synchronized enable is detected.
- R11: Every rising edge of enable restarts the edge count at zero, so an aborted or short command has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus enable; high frames a command |
| bus_clk | input | 1 | Bus bit clock; data is taken on its rising edge |
| bus_dat | input | 1 | Bus serial data |
| ref_div | output | 16 | Reference divider value |
| lvl3_code | output | 3 | Three-bit level DAC code |
| obuf_off | output | 1 | Oscillator buffer disable (1 = off) |
| pump_code | output | 2 | Charge-pump current code |
| fb_div | output | 16 | Feedback divider value |
| sw_off | output | 4 | Switch controls (1 = released, 0 = pulled low) |
| dac_am | output | 1 | Alignment DAC mode (1 = AM, 0 = FM) |
| stat_flag | output | 1 | Status flag bit |
| dac1_gain | output | 8 | DAC1 gain code |
| dac1_ofs | output | 6 | DAC1 offset code |
| dac2_gain | output | 8 | DAC2 gain code |
| dac2_ofs | output | 6 | DAC2 offset code |
| xtal_code | output | 8 | Crystal tuning-capacitance code |

## Verification
A wrong edge count or a shift register misaligned by one bit is not visible while a command is in progress. It shows only at the following commit, within about three system cycles of enable falling, as a field loaded into the wrong register, a value shifted by one bit, or a foreign-length command that is wrongly accepted. A stale count carried over from an aborted command corrupts the very next command. Divider underflow is visible as soon as a 0 or 1 reaches a divider output. Field updates that are not atomic show as an output that moves while enable is still high.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int WORD_W  = 24;
  localparam int SHORT_W = 16;
  localparam int DIV_W   = 16;
  localparam int DIV_MIN = 2;
  localparam int CNT_W   = 6;

  typedef enum logic [2:0] {
    K_NONE, K_REFW, K_FBW, K_DAC1, K_DAC2, K_XTAL
  } tw_kind_e;

  typedef struct packed {
    logic [DIV_W-1:0] ref_div;
    logic [2:0]       lvl3;
    logic             obuf_off;
    logic [1:0]       pump;
    logic [DIV_W-1:0] fb_div;
    logic [3:0]       sw_off;
    logic             dac_am;
    logic             stat;
    logic [7:0]       g1;
    logic [5:0]       o1;
    logic [7:0]       g2;
    logic [5:0]       o2;
    logic [7:0]       xtal;
  } tw_cfg_t;

  localparam tw_cfg_t TW_CFG_RST = '{
    ref_div: DIV_W'(DIV_MIN), lvl3: 3'd0, obuf_off: 1'b0, pump: 2'd0,
    fb_div: DIV_W'(DIV_MIN), sw_off: 4'hF, dac_am: 1'b0, stat: 1'b0,
    g1: 8'h80, o1: 6'h20, g2: 8'h80, o2: 6'h20, xtal: 8'h00};

  // Address bits are the two top bits of the received word for both lengths,
  // since a short word sits left-aligned in the shift register.
  function automatic tw_kind_e tw_classify(input logic [CNT_W-1:0] cnt,
                                           input logic [WORD_W-1:0] sh);
    logic [1:0] a;
    tw_classify = K_NONE;
    a = sh[WORD_W-1 -: 2];
    if (cnt == CNT_W'(WORD_W)) begin
      if (sh[DIV_W-1:0] >= DIV_W'(DIV_MIN)) begin
        if (a == 2'b00) tw_classify = K_REFW;
        else if (a == 2'b01) tw_classify = K_FBW;
      end
    end else if (cnt == CNT_W'(SHORT_W)) begin
      case (a)
        2'b00:   tw_classify = K_DAC1;
        2'b01:   tw_classify = K_DAC2;
        2'b10:   tw_classify = K_XTAL;
        default: tw_classify = K_NONE;
      endcase
    end
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], async_in[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~last;
    assign fall[g] = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/tw_frame_cap.sv
module tw_frame_cap #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              ck_rise,
  input  logic              dat_lvl,
  output logic [WORD_W-1:0] shreg,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      bit_cnt <= '0;
    end else if (ck_rise && en_lvl) begin
      shreg <= {dat_lvl, shreg[WORD_W-1:1]};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  tw_kind_e          kind,
  input  logic [WORD_W-1:0] shreg,
  output tw_cfg_t           cfg_q
);
  logic [SHORT_W-1:0] w16;
  assign w16 = shreg[WORD_W-1 -: SHORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= TW_CFG_RST;
    end else if (commit) begin
      case (kind)
        K_REFW: begin
          cfg_q.ref_div  <= shreg[15:0];
          cfg_q.lvl3     <= shreg[18:16];
          cfg_q.obuf_off <= shreg[19];
          cfg_q.pump     <= shreg[21:20];
        end
        K_FBW: begin
          cfg_q.fb_div <= shreg[15:0];
          cfg_q.sw_off <= shreg[19:16];
          cfg_q.dac_am <= shreg[20];
          cfg_q.stat   <= shreg[21];
        end
        K_DAC1: begin
          cfg_q.g1 <= w16[7:0];
          cfg_q.o1 <= w16[13:8];
        end
        K_DAC2: begin
          cfg_q.g2 <= w16[7:0];
          cfg_q.o2 <= w16[13:8];
        end
        K_XTAL:  cfg_q.xtal <= w16[13:6];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
  import tw_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_clk,
  input  logic        bus_dat,
  output logic [15:0] ref_div,
  output logic [2:0]  lvl3_code,
  output logic        obuf_off,
  output logic [1:0]  pump_code,
  output logic [15:0] fb_div,
  output logic [3:0]  sw_off,
  output logic        dac_am,
  output logic        stat_flag,
  output logic [7:0]  dac1_gain,
  output logic [5:0]  dac1_ofs,
  output logic [7:0]  dac2_gain,
  output logic [5:0]  dac2_ofs,
  output logic [7:0]  xtal_code
);
  localparam int CFG_W = $bits(tw_cfg_t);

  logic [2:0] lvl_v, rise_v, fall_v;
  logic       en_lvl, evt_en_rise, evt_en_fall, evt_ck_rise, dat_lvl;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  tw_kind_e          cmd_kind;
  tw_cfg_t           cfg_q;
  logic [CFG_W-1:0]  cfg_flat;
  logic              unused_evt;

  tw_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({bus_dat, bus_clk, bus_en}),
    .lvl(lvl_v), .rise(rise_v), .fall(fall_v));

  assign en_lvl      = lvl_v[0];
  assign evt_en_rise = rise_v[0];
  assign evt_en_fall = fall_v[0];
  assign evt_ck_rise = rise_v[1];
  assign dat_lvl     = lvl_v[2];
  assign unused_evt  = ^{lvl_v[1], rise_v[2], fall_v[2:1]};

  tw_frame_cap #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .en_rise(evt_en_rise),
    .ck_rise(evt_ck_rise), .dat_lvl(dat_lvl), .shreg(shreg), .bit_cnt(bit_cnt));

  assign cmd_kind = tw_classify(bit_cnt, shreg);

  tw_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit(evt_en_fall), .kind(cmd_kind),
    .shreg(shreg), .cfg_q(cfg_q));

  assign cfg_flat  = cfg_q;
  assign ref_div   = cfg_q.ref_div;
  assign lvl3_code = cfg_q.lvl3;
  assign obuf_off  = cfg_q.obuf_off;
  assign pump_code = cfg_q.pump;
  assign fb_div    = cfg_q.fb_div;
  assign sw_off    = cfg_q.sw_off;
  assign dac_am    = cfg_q.dac_am;
  assign stat_flag = cfg_q.stat;
  assign dac1_gain = cfg_q.g1;
  assign dac1_ofs  = cfg_q.o1;
  assign dac2_gain = cfg_q.g2;
  assign dac2_ofs  = cfg_q.o2;
  assign xtal_code = cfg_q.xtal;
endmodule

// File: rtl/tw_cfg_chk.sv
module tw_cfg_chk
  import tw_cfg_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         en_lvl,
  input logic                         evt_en_rise,
  input logic                         evt_en_fall,
  input logic                         evt_ck_rise,
  input logic [CNT_W-1:0]             bit_cnt,
  input logic [$bits(tw_cfg_t)-1:0]   cfg_flat,
  input logic [15:0]                  ref_div,
  input logic [15:0]                  fb_div
);
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(evt_en_fall) |-> $stable(cfg_flat)); // R10

  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_en_fall) && ($past(bit_cnt) != CNT_W'(16)) && ($past(bit_cnt) != CNT_W'(24)))
    |-> $stable(cfg_flat)); // R7

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    evt_en_rise |=> (bit_cnt == '0)); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ck_rise && en_lvl && !evt_en_rise && (bit_cnt != {CNT_W{1'b1}}))
    |=> (bit_cnt == $past(bit_cnt) + 1'b1)); // R2

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_div >= 16'd2) && (fb_div >= 16'd2)); // R9
endmodule

bind tw_cfg_slave tw_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .evt_en_rise(evt_en_rise),
  .evt_en_fall(evt_en_fall), .evt_ck_rise(evt_ck_rise), .bit_cnt(bit_cnt),
  .cfg_flat(cfg_flat), .ref_div(ref_div), .fb_div(fb_div));

// File: tb/tw_cfg_slave_tb_top.sv
module tw_cfg_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;

  logic [15:0] ref_div, fb_div;
  logic [2:0]  lvl3_code;
  logic        obuf_off, dac_am, stat_flag;
  logic [1:0]  pump_code;
  logic [3:0]  sw_off;
  logic [7:0]  dac1_gain, dac2_gain, xtal_code;
  logic [5:0]  dac1_ofs, dac2_ofs;

  int total = 0;
  int bad = 0;

  // bench model
  logic [15:0] m_ref, m_fb;
  logic [2:0]  m_lvl;
  logic        m_boff, m_am, m_stat;
  logic [1:0]  m_pump;
  logic [3:0]  m_sw;
  logic [7:0]  m_g1, m_g2, m_x;
  logic [5:0]  m_o1, m_o2;

  always #5 clk = ~clk;

  tw_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .ref_div(ref_div), .lvl3_code(lvl3_code), .obuf_off(obuf_off), .pump_code(pump_code),
    .fb_div(fb_div), .sw_off(sw_off), .dac_am(dac_am), .stat_flag(stat_flag),
    .dac1_gain(dac1_gain), .dac1_ofs(dac1_ofs), .dac2_gain(dac2_gain),
    .dac2_ofs(dac2_ofs), .xtal_code(xtal_code));

  wire [79:0] act = {ref_div, lvl3_code, obuf_off, pump_code, fb_div, sw_off, dac_am,
                     stat_flag, dac1_gain, dac1_ofs, dac2_gain, dac2_ofs, xtal_code};
  wire [79:0] expv = {m_ref, m_lvl, m_boff, m_pump, m_fb, m_sw, m_am, m_stat,
                      m_g1, m_o1, m_g2, m_o2, m_x};

  task automatic model_reset();
    m_ref = 16'd2; m_fb = 16'd2; m_lvl = '0; m_boff = 1'b0; m_pump = '0;
    m_sw = 4'hF; m_am = 1'b0; m_stat = 1'b0;
    m_g1 = 8'd128; m_g2 = 8'd128; m_o1 = 6'd32; m_o2 = 6'd32; m_x = '0;
  endtask

  task automatic model_apply(input int n, input logic [31:0] w);
    if (n == 24) begin
      if (w[23:22] == 2'b00 && w[15:0] > 16'd1) begin
        m_ref = w[15:0]; m_lvl = w[18:16]; m_boff = w[19]; m_pump = w[21:20];
      end else if (w[23:22] == 2'b01 && w[15:0] > 16'd1) begin
        m_fb = w[15:0]; m_sw = w[19:16]; m_am = w[20]; m_stat = w[21];
      end
    end else if (n == 16) begin
      case (w[15:14])
        2'b00: begin m_g1 = w[7:0]; m_o1 = w[13:8]; end
        2'b01: begin m_g2 = w[7:0]; m_o2 = w[13:8]; end
        2'b10: m_x = w[13:6];
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(input int n, input logic [31:0] w);
    if (n == 24) begin
      if (w[23] == 1'b1) return "R8";
      if (w[15:0] < 16'd2) return "R9";
      return (w[22] == 1'b0) ? "R3" : "R4";
    end
    if (n == 16) begin
      if (w[15:14] == 2'b11) return "R8";
      return (w[15:14] == 2'b10) ? "R6" : "R5";
    end
    return "R7";
  endfunction

  task automatic check(input string tag, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(input int n, input logic [31:0] w, input string tag);
    @(negedge clk) bus_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bus_dat = w[i];
      repeat (4) @(negedge clk);
      bus_clk = 1'b1;
      repeat (4) @(negedge clk);
      bus_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R10", "outputs moved during command");
    bus_en = 1'b0;
    bus_dat = 1'b0;
    model_apply(n, w);
    repeat (8) @(negedge clk);
    check(tag, $sformatf("len=%0d word=%h", n, w));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset values");

    send(24, {8'h00, 2'b00, 2'b11, 1'b1, 3'b101, 16'h1234}, "R3");
    send(24, {8'h00, 2'b00, 2'b01, 1'b0, 3'b010, 16'h0001 << 15}, "R2");
    send(24, {8'h00, 2'b01, 1'b1, 1'b1, 4'b0101, 16'hBEEF}, "R4");
    send(16, {16'h0, 2'b00, 6'h15, 8'hA7}, "R5");
    send(16, {16'h0, 2'b01, 6'h2A, 8'h3C}, "R5");
    send(16, {16'h0, 2'b10, 8'hC3, 6'h3F}, "R6");
    send(16, {16'h0, 2'b10, 8'hC3, 6'h00}, "R6");
    send(25, {7'h0, 2'b00, 2'b10, 1'b0, 3'b111, 16'h5555, 1'b1}, "R7");
    send(23, {9'h0, 1'b0, 2'b10, 1'b0, 3'b111, 16'h5555}, "R7");
    send(30, 32'h3FFF_FFFF, "R7");
    send(16, {16'h0, 2'b11, 14'h3FFF}, "R8");
    send(24, {8'h00, 2'b10, 22'h3F_FFFF}, "R8");
    send(24, {8'h00, 2'b11, 22'h15_5555}, "R8");
    send(24, {8'h00, 2'b00, 6'h3F, 16'h0001}, "R9");
    send(24, {8'h00, 2'b01, 6'h00, 16'h0000}, "R9");
    send(24, {8'h00, 2'b01, 6'h0A, 16'h0002}, "R9");
    send(7, 32'h0000_007F, "R11");
    send(16, {16'h0, 2'b00, 6'h01, 8'hFE}, "R11");

    for (int k = 0; k < 200; k++) begin
      int unsigned r;
      int n;
      logic [31:0] w;
      r = $urandom % 10;
      w = $urandom;
      if (r < 3) n = 24;
      else if (r < 6 || r > 7) n = 16;
      else if (r == 7) begin
        n = 24;
        w[23] = 1'b0;
        w[15:0] = 16'($urandom % 2);
      end else begin
        n = 1 + int'($urandom % 30);
        if (n == 16 || n == 24) n = 17;
      end
      send(n, w, tag_of(n, w));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule